// File: doc/BRIEF.md
# Windowed Per-Line Interrupt Arbiter

This block collects a wide set of external interrupt lines and turns them into one registered request, carrying a vector number and a vector address for the handler. Vector numbers below a fixed first-line value are reserved for exceptions and are never produced. Each remaining vector maps to one input line, so the default configuration has 240 lines numbered 16 to 255. Every line has its own urgency level, enable bit and detection mode.

Software does not see a flat register map. It writes a vector number into a line-select register, and a small shared window of registers then reads and writes the settings of that one line. The same window holds a cancel register. A pulse-mode line latches its request on a rising edge, and software must clear that latch through the cancel register after servicing it. A separate base register sets where the vector table starts. The reported address is the base plus four bytes per vector.

The host port is a synchronous single-cycle bus. A write takes effect at the clock edge where it is presented. Read data appears on the data-out port one edge after the read strobe.

Top module: `irqw_top`

## Requirements
- R1: After reset, every line reads back urgency 1, enable 0 and mode 0 (level), the line-select register reads 16, the base reads 0, and no request is raised.
- R2: Register offsets on bus_addr are 0 line-select, 1 urgency (bits 3:0), 2 enable (bit 0), 3 mode (bit 0, 1 = pulse), 4 cancel (write bit 0 = 1), 5 vector base. Window reads return the selected line's field zero-extended, one edge after bus_rd. A cancel read returns 0.
- R3: A line-select write whose data lies outside 16..255 is ignored. The select register and the window keep pointing at the last valid line.
- R4: A level-mode line is pending exactly while its input is high.
- R5: A pulse-mode line becomes pending on a rising edge of its input and stays pending after the input falls, until it is cancelled. The latch captures edges even while the line is disabled.
- R6: Writing 1 to the cancel register clears the latched request of the selected pulse-mode line. If an edge arrives in the same cycle, the edge wins.
- R7: A cancel write aimed at a level-mode line does not change that line's pending state.
- R8: A disabled line never raises irq_req.
- R9: Among pending, enabled lines, the one with the numerically lowest urgency wins. Equal urgencies go to the lowest line number.
- R10: While irq_req is high, irq_vec is the winning vector and irq_vec_addr equals base + 4 * irq_vec. While irq_req is low, both read 0.
- R11: irq_req, irq_vec and irq_vec_addr are registered. They reflect inputs and settings one clock edge after those inputs and settings are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one edge after bus_rd |
| irq_in | input | 240 | External interrupt lines, bit k is vector 16+k |
| irq_req | output | 1 | An enabled line is pending |
| irq_vec | output | 8 | Winning vector number |
| irq_vec_addr | output | 32 | Vector table entry address of the winner |

## Verification
The bench walks every line on its own. It catches an off-by-one between line index and vector number, or a wrong address scale, because either one puts a wrong vector or address on the outputs. It then sweeps one line's urgency across all sixteen values against a fixed rival. This exposes an inverted comparison or a tie that goes to the higher line. The pulse tests check that a request survives its input falling and that it is captured while the line is disabled. A design that misses either would lose the request. Cancel writes are aimed at both a pulse line and a level line. Out-of-range select writes at 5, 256 and 300 must not move the window, and an unchecked select would show up on read-back as a changed line.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam int BUS_AW = 3;

  typedef enum logic [BUS_AW-1:0] {
    RA_SEL    = 3'd0,
    RA_PRIO   = 3'd1,
    RA_EN     = 3'd2,
    RA_MODE   = 3'd3,
    RA_CANCEL = 3'd4,
    RA_BASE   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irqw_cfg.sv
module irqw_cfg
  import irqw_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int FIRST_IRQ = 16,
  parameter int PRIO_W    = 4,
  parameter int DW        = 32,
  localparam int NUM_LINES = NUM_VEC - FIRST_IRQ,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic                        rd,
  input  logic [BUS_AW-1:0]           addr,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  output logic [NUM_LINES-1:0]        en_vec,
  output logic [NUM_LINES-1:0]        mode_vec,
  output logic [DW-1:0]               base,
  output logic                        cancel,
  output logic [LINE_W-1:0]           sel_line
);
  logic [VEC_W-1:0]  sel_q;
  logic [PRIO_W-1:0] prio_q [NUM_LINES];
  logic [DW-1:0]     base_q;
  logic              sel_ok;

  assign sel_ok   = (wdata >= DW'(FIRST_IRQ)) && (wdata < DW'(NUM_VEC));
  assign sel_line = LINE_W'(sel_q - VEC_W'(FIRST_IRQ));
  assign cancel   = wr && (addr == RA_CANCEL) && wdata[0];
  assign base     = base_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_flat
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= VEC_W'(FIRST_IRQ);
      base_q   <= '0;
      en_vec   <= '0;
      mode_vec <= '0;
      rdata    <= '0;
      for (int i = 0; i < NUM_LINES; i++) prio_q[i] <= PRIO_W'(1);
    end else begin
      if (wr) begin
        case (addr)
          RA_SEL:  if (sel_ok) sel_q <= wdata[VEC_W-1:0];
          RA_PRIO: prio_q[sel_line] <= wdata[PRIO_W-1:0];
          RA_EN:   en_vec[sel_line] <= wdata[0];
          RA_MODE: mode_vec[sel_line] <= wdata[0];
          RA_BASE: base_q <= wdata;
          default: ;
        endcase
      end
      if (rd) begin
        case (addr)
          RA_SEL:  rdata <= DW'(sel_q);
          RA_PRIO: rdata <= DW'(prio_q[sel_line]);
          RA_EN:   rdata <= DW'(en_vec[sel_line]);
          RA_MODE: rdata <= DW'(mode_vec[sel_line]);
          RA_BASE: rdata <= base_q;
          default: rdata <= '0;
        endcase
      end
    end
  end

  // R3
  sel_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == RA_SEL && !sel_ok) |=> $stable(sel_q));

  // R3
  sel_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q >= VEC_W'(FIRST_IRQ)));
endmodule

// File: rtl/irqw_pend.sv
module irqw_pend #(
  parameter int NUM_LINES = 240,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [NUM_LINES-1:0] mode_vec,
  input  logic                 cancel,
  input  logic [LINE_W-1:0]    sel_line,
  output logic [NUM_LINES-1:0] pend_vec
);
  logic [NUM_LINES-1:0] in_q, latch_q, rise;

  assign rise     = irq_in & ~in_q;
  assign pend_vec = (mode_vec & (latch_q | rise)) | (~mode_vec & irq_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q    <= '0;
      latch_q <= '0;
    end else begin
      in_q <= irq_in;
      for (int i = 0; i < NUM_LINES; i++) begin
        if (!mode_vec[i])
          latch_q[i] <= 1'b0;
        else if (rise[i])
          latch_q[i] <= 1'b1;
        else if (cancel && sel_line == LINE_W'(i))
          latch_q[i] <= 1'b0;
      end
    end
  end

  // R6
  cancel_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cancel && mode_vec[sel_line] && !rise[sel_line]) |=> !latch_q[$past(sel_line)]);

  // R5
  edge_latches_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_vec[sel_line] && rise[sel_line]) |=> latch_q[$past(sel_line)]);
endmodule

// File: rtl/irqw_arb.sv
module irqw_arb #(
  parameter int NUM_VEC   = 256,
  parameter int FIRST_IRQ = 16,
  parameter int PRIO_W    = 4,
  parameter int DW        = 32,
  localparam int NUM_LINES = NUM_VEC - FIRST_IRQ,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LINES-1:0]        req_vec,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
  input  logic [DW-1:0]               base,
  output logic                        irq_req,
  output logic [VEC_W-1:0]            irq_vec,
  output logic [DW-1:0]               irq_vec_addr
);
  logic              found;
  logic [PRIO_W-1:0] best_p;
  logic [LINE_W-1:0] best_i;
  logic [VEC_W-1:0]  win_vec;

  always_comb begin
    found  = 1'b0;
    best_p = '1;
    best_i = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req_vec[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best_p)) begin
        found  = 1'b1;
        best_p = prio_flat[i*PRIO_W +: PRIO_W];
        best_i = LINE_W'(i);
      end
    end
  end

  assign win_vec = VEC_W'(best_i) + VEC_W'(FIRST_IRQ);

  always_ff @(posedge clk) begin
    if (rst || !found) begin
      irq_req      <= 1'b0;
      irq_vec      <= '0;
      irq_vec_addr <= '0;
    end else begin
      irq_req      <= 1'b1;
      irq_vec      <= win_vec;
      irq_vec_addr <= base + (DW'(win_vec) << 2);
    end
  end

  // R10
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec >= VEC_W'(FIRST_IRQ)));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_vec == '0 && irq_vec_addr == '0));

  // R11
  no_req_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vec == '0) |=> !irq_req);
endmodule

// File: rtl/irqw_top.sv
module irqw_top
  import irqw_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int FIRST_IRQ = 16,
  parameter int PRIO_W    = 4,
  parameter int DW        = 32,
  localparam int NUM_LINES = NUM_VEC - FIRST_IRQ,
  localparam int VEC_W     = $clog2(NUM_VEC),
  localparam int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 irq_req,
  output logic [VEC_W-1:0]     irq_vec,
  output logic [DW-1:0]        irq_vec_addr
);
  logic [NUM_LINES*PRIO_W-1:0] prio_flat;
  logic [NUM_LINES-1:0]        en_vec, mode_vec, pend_vec, req_vec;
  logic [DW-1:0]               base;
  logic                        cancel;
  logic [LINE_W-1:0]           sel_line;

  irqw_cfg #(.NUM_VEC(NUM_VEC), .FIRST_IRQ(FIRST_IRQ), .PRIO_W(PRIO_W), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .prio_flat(prio_flat),
    .en_vec(en_vec), .mode_vec(mode_vec), .base(base),
    .cancel(cancel), .sel_line(sel_line));

  irqw_pend #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mode_vec(mode_vec),
    .cancel(cancel), .sel_line(sel_line), .pend_vec(pend_vec));

  assign req_vec = pend_vec & en_vec;

  irqw_arb #(.NUM_VEC(NUM_VEC), .FIRST_IRQ(FIRST_IRQ), .PRIO_W(PRIO_W), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .req_vec(req_vec), .prio_flat(prio_flat),
    .base(base), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_vec_addr(irq_vec_addr));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (en_vec == '0) |=> !irq_req);

  // R10
  addr_scale_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec_addr == $past(base) + (DW'(irq_vec) << 2)));
endmodule

// File: tb/sim_irqw_top.sv
`timescale 1ns/1ps
module sim_irqw_top;
  localparam int NL = 240;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_in = '0;
  logic          irq_req;
  logic [7:0]    irq_vec;
  logic [31:0]   irq_vec_addr;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqw_top u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_vec_addr(irq_vec_addr));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_line(int v, int p, int e, int m);
    wr(3'd0, v); wr(3'd1, p); wr(3'd2, e); wr(3'd3, m);
  endtask

  task automatic expect_out(string req, logic r, int v, logic [31:0] base);
    check(req, {31'b0, irq_req}, {31'b0, r});
    check(req, {24'b0, irq_vec}, r ? v : 0);
    check(req, irq_vec_addr, r ? base + 4 * v : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] base;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    check("R1 req", {31'b0, irq_req}, 0);
    rd(3'd0, d); check("R1 sel", d, 16);
    rd(3'd5, d); check("R1 base", d, 0);
    for (int v = 16; v < 256; v++) begin
      wr(3'd0, v);
      rd(3'd1, d); check("R1 prio", d, 1);
      rd(3'd2, d); check("R1 en", d, 0);
      rd(3'd3, d); check("R1 mode", d, 0);
    end
    rd(3'd4, d); check("R2 cancel reads 0", d, 0);

    // R10 R11 single-line sweep over every vector
    base = 32'h0000_1000;
    wr(3'd5, base);
    rd(3'd5, d); check("R2 base readback", d, base);
    for (int v = 16; v < 256; v++) begin
      wr(3'd0, v); wr(3'd2, 1);
      irq_in = '0; irq_in[v-16] = 1'b1;
      check("R11 not before edge", {31'b0, irq_req}, 0);
      tick();
      expect_out("R10 sweep", 1'b1, v, base);
      irq_in = '0;
      wr(3'd2, 0);
      tick();
      expect_out("R10 idle", 1'b0, 0, base);
    end

    // R8 disabled line
    set_line(33, 0, 0, 0);
    irq_in[17] = 1'b1; tick(); tick();
    expect_out("R8 disabled", 1'b0, 0, base);
    irq_in = '0;

    // R9 urgency ordering and ties
    set_line(20, 5, 1, 0); set_line(30, 3, 1, 0); set_line(40, 7, 1, 0);
    irq_in[4] = 1'b1; irq_in[14] = 1'b1; irq_in[24] = 1'b1;
    tick(); expect_out("R9 lowest value", 1'b1, 30, base);
    wr(3'd0, 40); wr(3'd1, 3); tick(); expect_out("R9 tie low line", 1'b1, 30, base);
    wr(3'd0, 20); wr(3'd1, 3); tick(); expect_out("R9 tie low line", 1'b1, 20, base);
    wr(3'd0, 40); wr(3'd1, 0); tick(); expect_out("R9 urgent wins", 1'b1, 40, base);
    irq_in = '0;
    wr(3'd0, 20); wr(3'd2, 0); wr(3'd0, 30); wr(3'd2, 0); wr(3'd0, 40); wr(3'd2, 0);
    set_line(90, 8, 1, 0);
    irq_in[74] = 1'b1; irq_in[84] = 1'b1;
    for (int p = 0; p < 16; p++) begin
      set_line(100, p, 1, 0);
      tick();
      expect_out("R9 sweep", 1'b1, (p < 8) ? 100 : 90, base);
    end
    irq_in = '0;
    wr(3'd0, 90); wr(3'd2, 0); wr(3'd0, 100); wr(3'd2, 0);
    tick();

    // R5 R6 pulse latch and cancel
    set_line(50, 2, 1, 1);
    irq_in[34] = 1'b1; tick();
    expect_out("R5 edge", 1'b1, 50, base);
    irq_in[34] = 1'b0; tick(); tick();
    expect_out("R5 held", 1'b1, 50, base);
    wr(3'd4, 1);
    expect_out("R11 cancel latency", 1'b1, 50, base);
    tick();
    expect_out("R6 cancelled", 1'b0, 0, base);

    // R5 edge captured while disabled
    set_line(52, 2, 0, 1);
    irq_in[36] = 1'b1; tick(); irq_in[36] = 1'b0; tick();
    expect_out("R8 pulse disabled", 1'b0, 0, base);
    wr(3'd2, 1); tick();
    expect_out("R5 latched while off", 1'b1, 52, base);
    wr(3'd4, 1); tick();
    expect_out("R6 cancel 52", 1'b0, 0, base);

    // R7 cancel on level line, R4 level follows input
    set_line(60, 1, 1, 0);
    irq_in[44] = 1'b1; tick();
    wr(3'd4, 1); tick();
    expect_out("R7 level survives cancel", 1'b1, 60, base);
    irq_in[44] = 1'b0; tick();
    expect_out("R4 level drops", 1'b0, 0, base);
    wr(3'd2, 0);

    // R3 out-of-range select
    set_line(70, 9, 0, 0);
    wr(3'd0, 5); wr(3'd0, 256); wr(3'd0, 300);
    rd(3'd0, d); check("R3 sel kept", d, 70);
    rd(3'd1, d); check("R3 window kept", d, 9);
    wr(3'd0, 255);
    rd(3'd0, d); check("R3 top valid", d, 255);

    // R10 new base
    base = 32'h0002_0000;
    wr(3'd5, base);
    wr(3'd2, 1);
    irq_in[239] = 1'b1; tick();
    expect_out("R10 base", 1'b1, 255, base);
    irq_in = '0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule